// File: doc/BRIEF.md
# Control Transfer Stage and Data Toggle Sequencer

This block steps a host-side control pipe through the phases of one control transfer. A single start pulse carries the direction of the data phase and its byte count. The sequencer then presents the token for the current phase: SETUP first, then IN or OUT for the data packets, then the opposite direction for the handshake phase. Next to the token it shows the DATA0/DATA1 value that the transaction engine must send or expect. The transaction engine reports the outcome of each transaction with a completion pulse and a response code. The sequencer advances on ACK, repeats on NAK, and gives up on STALL. An abort input drops the transfer at any time.

The toggle is not free-running. Every time a new phase begins, the toggle is set to a fixed value tied to that phase's token: DATA0 for SETUP, and DATA1 for IN or OUT. Inside the data phase it then alternates with each acknowledged packet. The number of data packets is the byte count divided by the maximum packet size, rounded up. A byte count of zero skips the data phase entirely.

Top module: `ctl_pipe_seq`

## Requirements
- R1: After reset `stage` is 0 (idle), `token` is 0 (none), `toggle` is 0, and `done` and `error` are 0.
- R2: A `start` pulse is taken only while idle. The next cycle shows `stage`=1 (setup) and `token`=1 (SETUP). A `start` pulse while a transfer is running changes nothing.
- R3: The setup phase uses `toggle`=0 (DATA0). A response of NAK (`txn_resp`=1) or of the reserved code 3 repeats the transaction with stage, token and toggle unchanged.
- R4: When the setup phase is ACKed (`txn_resp`=0) and `data_len` is nonzero, the sequencer enters `stage`=2 (data) with `toggle`=1. The token is IN (2) when `dir_in` was 1 and OUT (3) when it was 0. The data phase lasts ceil(`data_len`/MPS) ACKed packets.
- R5: Within the data phase, `toggle` inverts after every ACKed packet and holds its value on NAK or on code 3.
- R6: The ACK of the last data packet moves the sequencer to `stage`=3 (status) with `toggle`=1. The token is the direction opposite to the data phase: OUT (3) after IN data, IN (2) after OUT data.
- R7: With `data_len`=0 the setup ACK goes straight to `stage`=3 with `token`=2 (IN) and `toggle`=1, whatever `dir_in` was.
- R8: An ACK in the status phase gives a `done` pulse lasting exactly one cycle and returns the sequencer to idle.
- R9: A STALL (`txn_resp`=2) in any phase gives an `error` pulse lasting one cycle. The sequencer returns to idle with `toggle`=0 and `done` stays 0.
- R10: `abort` returns the sequencer to idle on the next cycle with neither `done` nor `error`. It wins over a completion pulse or a `start` in the same cycle.
- R11: A `txn_done` pulse while idle is ignored. No state changes and no status pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a control transfer (taken only when idle) |
| dir_in | input | 1 | Data phase direction: 1 = device to host (IN), 0 = OUT |
| data_len | input | LEN_W | Data phase byte count, sampled with `start` |
| txn_done | input | 1 | One-cycle pulse: current transaction finished |
| txn_resp | input | 2 | Response for `txn_done`: 0 ACK, 1 NAK, 2 STALL, 3 treated as NAK |
| abort | input | 1 | Drop the transfer and return to idle |
| token | output | 2 | Current token: 0 none, 1 SETUP, 2 IN, 3 OUT |
| toggle | output | 1 | Data PID for the current transaction: 0 DATA0, 1 DATA1 |
| stage | output | 2 | Current phase: 0 idle, 1 setup, 2 data, 3 status |
| done | output | 1 | One-cycle pulse: transfer completed |
| error | output | 1 | One-cycle pulse: transfer ended by STALL |

## Verification
The bench builds the block with LEN_W=6 and MPS=8. Every byte count from 0 to 63 is then reachable in both directions, so the sweep covers zero-length transfers, exact multiples of the packet size and partial last packets, with up to eight data packets each. With packets that small, the alternation of the toggle is exercised over both odd and even packet counts. NAKs and reserved responses are interleaved at positions derived from the byte count. STALL in each phase, abort alone and abort in the same cycle as a status ACK, and start or completion pulses at the wrong moment are each driven as separate cases.

// File: rtl/ctl_pipe_pkg.sv
package ctl_pipe_pkg;

  typedef enum logic [1:0] {
    STG_IDLE   = 2'd0,
    STG_SETUP  = 2'd1,
    STG_DATA   = 2'd2,
    STG_STATUS = 2'd3
  } stage_e;

  typedef enum logic [1:0] {
    TOK_NONE  = 2'd0,
    TOK_SETUP = 2'd1,
    TOK_IN    = 2'd2,
    TOK_OUT   = 2'd3
  } tok_e;

  localparam logic [1:0] RSP_ACK   = 2'd0;
  localparam logic [1:0] RSP_NAK   = 2'd1;
  localparam logic [1:0] RSP_STALL = 2'd2;

  // Number of data packets for a byte count: ceiling division.
  function automatic logic [31:0] pkt_count(input logic [31:0] len, input int unsigned mps);
    return (len + mps - 1) / mps;
  endfunction

  // Token used while a given phase is active.
  function automatic tok_e tok_for(input stage_e s, input logic dir_in, input logic no_data);
    tok_e t;
    case (s)
      STG_SETUP:  t = TOK_SETUP;
      STG_DATA:   t = dir_in ? TOK_IN : TOK_OUT;
      STG_STATUS: t = (no_data || !dir_in) ? TOK_IN : TOK_OUT;
      default:    t = TOK_NONE;
    endcase
    return t;
  endfunction

  // Toggle forced at the start of a phase, chosen by that phase's token.
  function automatic logic init_toggle(input tok_e t);
    return (t == TOK_IN) || (t == TOK_OUT);
  endfunction

endpackage

// File: rtl/ctl_data_counter.sv
module ctl_data_counter #(
  parameter int LEN_W = 16,
  parameter int MPS   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             dec,
  output logic             len_zero,
  output logic             last
);
  import ctl_pipe_pkg::*;

  localparam int PKT_W = LEN_W + 1;

  logic [PKT_W-1:0] cnt_q;
  logic [PKT_W-1:0] load_val;

  assign load_val = PKT_W'(pkt_count(32'(len), MPS));
  assign len_zero = (load_val == '0);
  assign last     = (cnt_q == PKT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - PKT_W'(1);
  end

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));

endmodule

// File: rtl/ctl_toggle_reg.sv
module ctl_toggle_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic load,
  input  logic load_val,
  input  logic flip,
  output logic toggle
);
  logic tgl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tgl_q <= 1'b0;
    else if (clear) tgl_q <= 1'b0;
    else if (load)  tgl_q <= load_val;
    else if (flip)  tgl_q <= ~tgl_q;
  end

  assign toggle = tgl_q;

  // R5
  flip_inverts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && !load && !clear) |=> (tgl_q != $past(tgl_q)));

endmodule

// File: rtl/ctl_stage_fsm.sv
module ctl_stage_fsm (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  dir_in,
  input  logic                  no_data_in,
  input  logic                  txn_done,
  input  logic [1:0]            txn_resp,
  input  logic                  abort,
  input  logic                  last_data,
  output ctl_pipe_pkg::stage_e  stage,
  output ctl_pipe_pkg::tok_e    token,
  output logic                  start_acc,
  output logic                  stage_enter,
  output ctl_pipe_pkg::tok_e    enter_token,
  output logic                  data_ack,
  output logic                  to_idle,
  output logic                  done,
  output logic                  error
);
  import ctl_pipe_pkg::*;

  stage_e stage_q, stage_d;
  logic   dir_q, dir_d;
  logic   nodata_q, nodata_d;
  logic   done_q, err_q;
  logic   live, acc, ack_evt, stall_evt;

  assign live      = (stage_q != STG_IDLE);
  assign acc       = txn_done && live && !abort;
  assign ack_evt   = acc && (txn_resp == RSP_ACK);
  assign stall_evt = acc && (txn_resp == RSP_STALL);
  assign start_acc = !live && start && !abort;

  always_comb begin
    stage_d  = stage_q;
    dir_d    = dir_q;
    nodata_d = nodata_q;
    case (stage_q)
      STG_IDLE: if (start_acc) begin
        stage_d  = STG_SETUP;
        dir_d    = dir_in;
        nodata_d = no_data_in;
      end
      STG_SETUP: begin
        if (stall_evt)    stage_d = STG_IDLE;
        else if (ack_evt) stage_d = nodata_q ? STG_STATUS : STG_DATA;
      end
      STG_DATA: begin
        if (stall_evt)                 stage_d = STG_IDLE;
        else if (ack_evt && last_data) stage_d = STG_STATUS;
      end
      STG_STATUS: begin
        if (stall_evt || ack_evt) stage_d = STG_IDLE;
      end
      default: stage_d = STG_IDLE;
    endcase
    if (abort) stage_d = STG_IDLE;
  end

  assign stage_enter = (stage_d != stage_q) && (stage_d != STG_IDLE);
  assign enter_token = tok_for(stage_d, dir_d, nodata_d);
  assign data_ack    = ack_evt && (stage_q == STG_DATA);
  assign to_idle     = (stage_d == STG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= STG_IDLE;
      dir_q    <= 1'b0;
      nodata_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      stage_q  <= stage_d;
      dir_q    <= dir_d;
      nodata_q <= nodata_d;
      done_q   <= ack_evt && (stage_q == STG_STATUS);
      err_q    <= stall_evt;
    end
  end

  assign stage = stage_q;
  assign token = tok_for(stage_q, dir_q, nodata_q);
  assign done  = done_q;
  assign error = err_q;

  // R2
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && start && !txn_done && !abort) |=> $stable(stage_q));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/ctl_pipe_seq.sv
module ctl_pipe_seq #(
  parameter int LEN_W = 16,
  parameter int MPS   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_in,
  input  logic [LEN_W-1:0] data_len,
  input  logic             txn_done,
  input  logic [1:0]       txn_resp,
  input  logic             abort,
  output logic [1:0]       token,
  output logic             toggle,
  output logic [1:0]       stage,
  output logic             done,
  output logic             error
);
  import ctl_pipe_pkg::*;

  stage_e stage_w;
  tok_e   token_w;
  tok_e   enter_tok_w;
  logic   start_acc_w, stage_enter_w, data_ack_w, to_idle_w;
  logic   len_zero_w, last_w, toggle_w;

  ctl_stage_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dir_in      (dir_in),
    .no_data_in  (len_zero_w),
    .txn_done    (txn_done),
    .txn_resp    (txn_resp),
    .abort       (abort),
    .last_data   (last_w),
    .stage       (stage_w),
    .token       (token_w),
    .start_acc   (start_acc_w),
    .stage_enter (stage_enter_w),
    .enter_token (enter_tok_w),
    .data_ack    (data_ack_w),
    .to_idle     (to_idle_w),
    .done        (done),
    .error       (error)
  );

  ctl_data_counter #(.LEN_W(LEN_W), .MPS(MPS)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_acc_w),
    .len      (data_len),
    .dec      (data_ack_w),
    .len_zero (len_zero_w),
    .last     (last_w)
  );

  ctl_toggle_reg u_tgl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (to_idle_w),
    .load     (stage_enter_w),
    .load_val (init_toggle(enter_tok_w)),
    .flip     (data_ack_w),
    .toggle   (toggle_w)
  );

  assign token  = token_w;
  assign stage  = stage_w;
  assign toggle = toggle_w;

  // R3
  setup_dat0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_w == STG_SETUP && $past(stage_w) == STG_IDLE) |-> !toggle_w);

  // R6
  entry_dat1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stage_w == STG_DATA || stage_w == STG_STATUS) && $past(stage_w) != stage_w) |-> toggle_w);

  // R5
  nak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && txn_resp != RSP_ACK && txn_resp != RSP_STALL && !abort && stage_w != STG_IDLE)
      |=> ($stable(toggle_w) && $stable(stage_w)));

  // R9
  stall_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_done && txn_resp == RSP_STALL && !abort && stage_w != STG_IDLE)
      |=> (error && !done && stage_w == STG_IDLE && !toggle_w));

  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (stage_w == STG_IDLE && !done && !error));

  // R11
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_w == STG_IDLE && !start) |=> (stage_w == STG_IDLE && !done && !error && !toggle_w));

  // R8
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));

endmodule

// File: tb/ctl_pipe_seq_bench.sv
module ctl_pipe_seq_bench;
  localparam int LW  = 6;
  localparam int MPS = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          dir_in = 1'b0;
  logic [LW-1:0] data_len = '0;
  logic          txn_done = 1'b0;
  logic [1:0]    txn_resp = 2'd0;
  logic          abort = 1'b0;
  logic [1:0]    token;
  logic          toggle;
  logic [1:0]    stage;
  logic          done;
  logic          error;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ctl_pipe_seq #(.LEN_W(LW), .MPS(MPS)) u_ctl_pipe_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_in(dir_in), .data_len(data_len),
    .txn_done(txn_done), .txn_resp(txn_resp), .abort(abort),
    .token(token), .toggle(toggle), .stage(stage), .done(done), .error(error)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req, input int stg, input int tok, input int tgl);
    check(req, "stage", int'(stage), stg);
    check(req, "token", int'(token), tok);
    check(req, "toggle", int'(toggle), tgl);
  endtask

  task automatic check_flags(input string req, input int d, input int e);
    check(req, "done", int'(done), d);
    check(req, "error", int'(error), e);
  endtask

  task automatic pulse_txn(input logic [1:0] rsp);
    txn_done = 1'b1;
    txn_resp = rsp;
    @(negedge clk);
    txn_done = 1'b0;
    txn_resp = 2'd0;
  endtask

  task automatic begin_xfer(input int len, input bit dir);
    data_len = LW'(len);
    dir_in   = dir;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  // Full transfer with NAKs and reserved responses interleaved.
  task automatic run_xfer(input int len, input bit dir);
    int pk;
    int stok;
    begin_xfer(len, dir);
    check_state("R2", 1, 1, 0);
    if ((len % 3) == 1) begin
      pulse_txn(2'd1);
      check_state("R3", 1, 1, 0);
    end
    pulse_txn(2'd0);
    pk = (len + MPS - 1) / MPS;
    for (int i = 0; i < pk; i++) begin
      check_state((i == 0) ? "R4" : "R5", 2, dir ? 2 : 3, ((i % 2) == 0) ? 1 : 0);
      if (((len + i) % 4) == 0) begin
        pulse_txn(((i % 2) == 1) ? 2'd3 : 2'd1);
        check_state("R5", 2, dir ? 2 : 3, ((i % 2) == 0) ? 1 : 0);
      end
      pulse_txn(2'd0);
    end
    stok = (pk != 0 && dir) ? 3 : 2;
    check_state((pk == 0) ? "R7" : "R6", 3, stok, 1);
    pulse_txn(2'd0);
    check_flags("R8", 1, 0);
    check_state("R8", 0, 0, 0);
    @(negedge clk);
    check_flags("R8", 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1", 0, 0, 0);
    check_flags("R1", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 0, 0, 0);

    // R11: completion pulses while idle
    pulse_txn(2'd0);
    check_state("R11", 0, 0, 0);
    check_flags("R11", 0, 0);
    pulse_txn(2'd2);
    check_flags("R11", 0, 0);

    // Sweep every byte count in both directions
    for (int d = 0; d < 2; d++)
      for (int len = 0; len < (1 << LW); len++)
        run_xfer(len, d[0]);

    // R2: start while busy ignored; R9: stall in data phase
    begin_xfer(20, 1'b1);
    pulse_txn(2'd0);
    begin_xfer(5, 1'b0);
    check_state("R2", 2, 2, 1);
    pulse_txn(2'd2);
    check_flags("R9", 0, 1);
    check_state("R9", 0, 0, 0);
    @(negedge clk);
    check_flags("R9", 0, 0);

    // R9: stall in setup phase
    begin_xfer(9, 1'b0);
    pulse_txn(2'd2);
    check_flags("R9", 0, 1);
    check_state("R9", 0, 0, 0);

    // R9: stall in status phase
    begin_xfer(0, 1'b1);
    pulse_txn(2'd0);
    check_state("R7", 3, 2, 1);
    pulse_txn(2'd2);
    check_flags("R9", 0, 1);
    check_state("R9", 0, 0, 0);

    // R10: abort mid data phase
    begin_xfer(30, 1'b0);
    pulse_txn(2'd0);
    pulse_txn(2'd0);
    check_state("R5", 2, 3, 0);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check_state("R10", 0, 0, 0);
    check_flags("R10", 0, 0);

    // R10: abort together with status ACK
    begin_xfer(0, 1'b0);
    pulse_txn(2'd0);
    abort = 1'b1;
    pulse_txn(2'd0);
    abort = 1'b0;
    check_state("R10", 0, 0, 0);
    check_flags("R10", 0, 0);

    // R10: abort together with start
    abort = 1'b1;
    begin_xfer(8, 1'b1);
    abort = 1'b0;
    check_state("R10", 0, 0, 0);

    // Recovery after abort: a fresh transfer runs cleanly
    run_xfer(17, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule